// File: doc/BRIEF.md
# Five-Source Prioritized Interrupt Unit with Mask Register

This unit sits beside a small processor core and decides which interrupt the core takes next. It has five request inputs. The highest is a trap that cannot be masked. Below it are three restart requests, each with its own mask bit, and at the bottom is one general request. Each cycle the unit offers the core the highest request that is currently allowed. For the three restart requests and the trap it also supplies the entry address. These entry points sit in the middle of the normal 8-byte restart slots. For the general request the core fetches its own instruction from the bus, so the unit reports vector zero. When the core accepts the offer it pulses `ack`. The unit then clears the one-shot state of the accepted source. If that source is maskable, it also drops the global enable.

Software reaches the unit through two byte-wide paths. A set-mask write takes an accumulator byte and can, in one write, change the three mask bits, clear the edge-captured request, and drive the serial output pin. A control bit inside the byte gates each of these changes. A read-mask byte returns the masks, the global enable, the three restart pending flags and the serial input pin. Single-cycle enable and disable strobes set and clear the global enable.

Top module: `intr_prio_unit`

## Requirements
- R1: At most one bit of `irq_grant` is high. Bit 4 is the trap, bit 3 the edge restart, bit 2 the upper level restart, bit 1 the lower level restart and bit 0 the general request. The granted source is always the highest-numbered request that is allowed.
- R2: The trap is granted regardless of the global enable and the masks. It is granted only after the input has been seen low and then high at a clock edge, and only while the input stays high. After it is acknowledged, it is not granted again until the input falls and rises again.
- R3: A restart request is granted only if its mask bit is 0 and the global enable is 1. The general request is granted only if the global enable is 1.
- R4: `irq_vec` is 0x0024 for the trap, 0x003C for the edge restart, 0x0034 for the upper level restart and 0x002C for the lower level restart. It is 0x0000 for the general request and when nothing is granted.
- R5: A set-mask write with bit 3 set loads the mask bits. Data bit 0 masks the lower level restart, bit 1 the upper level restart and bit 2 the edge restart. With bit 3 clear, the masks are unchanged.
- R6: A set-mask write with bit 6 set copies data bit 7 to `ser_out`. With bit 6 clear, `ser_out` is unchanged.
- R7: A rising edge on the edge restart input sets a pending flag. The flag is set even when that source is masked, and it stays set after the input falls. The flag is cleared by acknowledging that source, by a set-mask write with bit 4 set, or by reset.
- R8: `rmask_data` bits 2:0 are the masks, bit 3 is the global enable, bit 4 is the lower level input, bit 5 is the upper level input, bit 6 is the edge pending flag and bit 7 is `ser_in`.
- R9: The enable strobe sets the global enable and the disable strobe clears it. Acknowledging any maskable source also clears it. Acknowledging the trap leaves it unchanged.
- R10: After reset the global enable is 0, all masks are 1, `ser_out` is 0, the edge flag is clear and nothing is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Non-maskable trap request |
| r75_req | input | 1 | Edge-captured restart request |
| r65_req | input | 1 | Upper level-sensitive restart request |
| r55_req | input | 1 | Lower level-sensitive restart request |
| gen_req | input | 1 | General level-sensitive request |
| ei_stb | input | 1 | Global enable strobe |
| di_stb | input | 1 | Global disable strobe |
| smask_wr | input | 1 | Set-mask write strobe |
| smask_data | input | 8 | Set-mask accumulator byte |
| ser_in | input | 1 | Serial input pin |
| ack | input | 1 | Core accepts the offered request |
| irq_valid | output | 1 | A request is offered |
| irq_grant | output | 5 | One-hot granted source |
| irq_vec | output | VEC_W | Entry address of the granted restart |
| rmask_data | output | 8 | Read-mask byte |
| ser_out | output | 1 | Serial output pin |

## Verification
A table drives the level requests in combinations of all three, pairs and singles, each against different mask patterns and both enable states. These cases separate the priority chain from the gating, since a masked high source has to give way to the next one down. The directed runs then cover several cases. One pulses the edge request while it is masked, so that capturing the request can be told apart from granting it. Another holds the trap high across an acknowledge and also drops it before acceptance, which separates edge arming from a plain level request. Set-mask bytes with one control bit set and the other clear show that the masks and the serial output are gated independently.

// File: rtl/intr_pkg.sv
package intr_pkg;
   localparam int NSRC      = 5;
   localparam int SRC_GEN   = 0;
   localparam int SRC_LO    = 1;
   localparam int SRC_MID   = 2;
   localparam int SRC_EDGE  = 3;
   localparam int SRC_TRAP  = 4;
   // set-mask byte control positions
   localparam int SM_MSK_EN = 3;
   localparam int SM_CLR_E  = 4;
   localparam int SM_SO_EN  = 6;
   localparam int SM_SO_DAT = 7;
endpackage

// File: rtl/intr_edge_latch.sv
module intr_edge_latch #(
   parameter bit STICKY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic clr,
   output logic live
);
   logic prev_q, hit_q, hit_d, rise;

   assign rise = req & ~prev_q;

   generate
      if (STICKY) begin : g_sticky
         assign hit_d = clr ? 1'b0 : (rise ? 1'b1 : hit_q);
         assign live  = hit_q;
      end else begin : g_armed
         assign hit_d = (clr | ~req) ? 1'b0 : (rise ? 1'b1 : hit_q);
         assign live  = hit_q & req;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         hit_q  <= 1'b0;
      end else begin
         prev_q <= req;
         hit_q  <= hit_d;
      end
   end

   a_r7_clr_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !hit_q);
   a_r2_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_q && !rise) |=> !hit_q);
endmodule

// File: rtl/intr_prio_arb.sv
module intr_prio_arb #(
   parameter int N = 5
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   if (N < 2) begin : g_bad_n
      $error("intr_prio_arb: N must be at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_slot
      if (i == N-1) begin : g_top
         assign grant[i] = req[i];
      end else begin : g_low
         assign grant[i] = req[i] & ~(|req[N-1:i+1]);
      end
   end
endmodule

// File: rtl/intr_mask_reg.sv
module intr_mask_reg
   import intr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] data,
   input  logic       ei,
   input  logic       di,
   input  logic       take,
   output logic [2:0] mask,
   output logic       ie,
   output logic       ser_out
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask    <= 3'b111;
         ie      <= 1'b0;
         ser_out <= 1'b0;
      end else begin
         if (wr && data[SM_MSK_EN]) mask    <= data[2:0];
         if (wr && data[SM_SO_EN])  ser_out <= data[SM_SO_DAT];
         if (take || di)            ie      <= 1'b0;
         else if (ei)               ie      <= 1'b1;
      end
   end

   a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !data[SM_MSK_EN]) |=> $stable(mask));
   a_r6_sod_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !data[SM_SO_EN]) |=> $stable(ser_out));
   a_r9_take_drops: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !ie);
endmodule

// File: rtl/intr_prio_unit.sv
module intr_prio_unit
   import intr_pkg::*;
#(
   parameter int VEC_W      = 16,
   parameter int SLOT_BYTES = 8,
   parameter int TRAP_SLOT  = 4,
   parameter int LO_SLOT    = 5,
   parameter int MID_SLOT   = 6,
   parameter int EDGE_SLOT  = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trap_req,
   input  logic             r75_req,
   input  logic             r65_req,
   input  logic             r55_req,
   input  logic             gen_req,
   input  logic             ei_stb,
   input  logic             di_stb,
   input  logic             smask_wr,
   input  logic [7:0]       smask_data,
   input  logic             ser_in,
   input  logic             ack,
   output logic             irq_valid,
   output logic [4:0]       irq_grant,
   output logic [VEC_W-1:0] irq_vec,
   output logic [7:0]       rmask_data,
   output logic             ser_out
);
   localparam int HALF = SLOT_BYTES / 2;
   localparam logic [VEC_W-1:0] VTAB [NSRC] = '{
      VEC_W'(0),
      VEC_W'(LO_SLOT   * SLOT_BYTES + HALF),
      VEC_W'(MID_SLOT  * SLOT_BYTES + HALF),
      VEC_W'(EDGE_SLOT * SLOT_BYTES + HALF),
      VEC_W'(TRAP_SLOT * SLOT_BYTES + HALF)};

   if (SLOT_BYTES < 2 || (SLOT_BYTES % 2) != 0) begin : g_bad_slot
      $error("intr_prio_unit: SLOT_BYTES must be even and at least 2");
   end
   if ((EDGE_SLOT + 1) * SLOT_BYTES > (2 ** VEC_W)) begin : g_bad_w
      $error("intr_prio_unit: VEC_W too narrow for restart slots");
   end

   logic [2:0]      mask;
   logic            ie, edge_pend, trap_live;
   logic [NSRC-1:0] req;
   logic            take_mask, clr_edge, clr_trap;

   intr_mask_reg u_mreg (
      .clk(clk), .rst_n(rst_n), .wr(smask_wr), .data(smask_data),
      .ei(ei_stb), .di(di_stb), .take(take_mask),
      .mask(mask), .ie(ie), .ser_out(ser_out));

   intr_edge_latch #(.STICKY(1'b1)) u_edge (
      .clk(clk), .rst_n(rst_n), .req(r75_req), .clr(clr_edge), .live(edge_pend));

   intr_edge_latch #(.STICKY(1'b0)) u_trap (
      .clk(clk), .rst_n(rst_n), .req(trap_req), .clr(clr_trap), .live(trap_live));

   assign req[SRC_TRAP] = trap_live;
   assign req[SRC_EDGE] = edge_pend & ~mask[2] & ie;
   assign req[SRC_MID]  = r65_req   & ~mask[1] & ie;
   assign req[SRC_LO]   = r55_req   & ~mask[0] & ie;
   assign req[SRC_GEN]  = gen_req   & ie;

   intr_prio_arb #(.N(NSRC)) u_arb (.req(req), .grant(irq_grant));

   assign irq_valid = |irq_grant;
   assign take_mask = ack & (|irq_grant[SRC_EDGE:SRC_GEN]);
   assign clr_trap  = ack & irq_grant[SRC_TRAP];
   assign clr_edge  = (ack & irq_grant[SRC_EDGE]) | (smask_wr & smask_data[SM_CLR_E]);

   always_comb begin
      irq_vec = '0;
      for (int i = 0; i < NSRC; i++)
         if (irq_grant[i]) irq_vec = irq_vec | VTAB[i];
   end

   assign rmask_data = {ser_in, edge_pend, r65_req, r55_req, ie, mask};

   a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_grant));
   a_r2_trap_first: assert property (@(posedge clk) disable iff (!rst_n)
      trap_live |-> irq_grant[SRC_TRAP]);
   a_r3_lo_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq_grant[SRC_LO] |-> (!mask[0] && ie && r55_req));
   a_r3_gen_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq_grant[SRC_GEN] |-> (ie && gen_req));
   a_r9_trap_keeps_ie: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_trap && !ei_stb && !di_stb) |=> $stable(ie));
endmodule

// File: tb/intr_prio_unit_bench.sv
`timescale 1ns/100ps
module intr_prio_unit_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trap_req = 0, r75_req = 0, r65_req = 0, r55_req = 0, gen_req = 0;
   logic ei_stb = 0, di_stb = 0, smask_wr = 0, ser_in = 0, ack = 0;
   logic [7:0]  smask_data = 8'h00;
   logic        irq_valid, ser_out;
   logic [4:0]  irq_grant;
   logic [15:0] irq_vec;
   logic [7:0]  rmask_data;
   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   intr_prio_unit u_intr_prio_unit (
      .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .r75_req(r75_req),
      .r65_req(r65_req), .r55_req(r55_req), .gen_req(gen_req),
      .ei_stb(ei_stb), .di_stb(di_stb), .smask_wr(smask_wr),
      .smask_data(smask_data), .ser_in(ser_in), .ack(ack),
      .irq_valid(irq_valid), .irq_grant(irq_grant), .irq_vec(irq_vec),
      .rmask_data(rmask_data), .ser_out(ser_out));

   typedef struct packed {
      logic       ie;
      logic [2:0] msk;
      logic       mid, lo, gen;
      logic [4:0] grant;
      logic [15:0] vec;
   } vec_t;

   localparam vec_t TBL [8] = '{
      '{1'b1, 3'b000, 1'b1, 1'b1, 1'b1, 5'b00100, 16'h0034},
      '{1'b1, 3'b000, 1'b0, 1'b1, 1'b1, 5'b00010, 16'h002C},
      '{1'b1, 3'b000, 1'b0, 1'b0, 1'b1, 5'b00001, 16'h0000},
      '{1'b1, 3'b010, 1'b1, 1'b1, 1'b1, 5'b00010, 16'h002C},
      '{1'b1, 3'b011, 1'b1, 1'b1, 1'b1, 5'b00001, 16'h0000},
      '{1'b0, 3'b000, 1'b1, 1'b1, 1'b1, 5'b00000, 16'h0000},
      '{1'b1, 3'b111, 1'b0, 1'b0, 1'b0, 5'b00000, 16'h0000},
      '{1'b1, 3'b001, 1'b1, 1'b1, 1'b0, 5'b00100, 16'h0034}};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_mask(input logic [7:0] b);
      @(negedge clk); smask_wr = 1'b1; smask_data = b;
      @(negedge clk); smask_wr = 1'b0; smask_data = 8'h00;
   endtask
   task automatic do_ei;
      @(negedge clk); ei_stb = 1'b1;
      @(negedge clk); ei_stb = 1'b0;
   endtask
   task automatic do_di;
      @(negedge clk); di_stb = 1'b1;
      @(negedge clk); di_stb = 1'b0;
   endtask
   task automatic do_ack;
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask
   task automatic pulse_edge;
      @(negedge clk); r75_req = 1'b1;
      @(negedge clk); r75_req = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", n_chk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk("R10 reset valid", irq_valid, 0);
      chk("R10 reset grant", irq_grant, 0);
      chk("R10 reset rmask (R8 layout)", rmask_data, 8'h07);
      chk("R10 reset ser_out", ser_out, 0);

      // table walk: R1 priority, R3 gating, R4 vectors
      for (int k = 0; k < 8; k++) begin
         @(negedge clk); r65_req = 0; r55_req = 0; gen_req = 0;
         wr_mask({5'b00001, TBL[k].msk});
         if (TBL[k].ie) do_ei; else do_di;
         @(negedge clk);
         r65_req = TBL[k].mid; r55_req = TBL[k].lo; gen_req = TBL[k].gen;
         #1;
         chk($sformatf("R1/R3 table %0d grant", k), irq_grant, TBL[k].grant);
         chk($sformatf("R4 table %0d vec", k), irq_vec, TBL[k].vec);
         chk($sformatf("R1 table %0d valid", k), irq_valid, |TBL[k].grant);
      end
      @(negedge clk); r65_req = 0; r55_req = 0; gen_req = 0;

      // R9 strobes
      do_ei; #1 chk("R9 enable strobe", rmask_data[3], 1);
      do_di; #1 chk("R9 disable strobe", rmask_data[3], 0);

      // R7 edge capture, priority, acknowledge
      do_ei; wr_mask(8'h08);
      pulse_edge; #1;
      chk("R7 edge granted after input fell", irq_grant, 5'b01000);
      chk("R4 edge vec", irq_vec, 16'h003C);
      chk("R7 edge pending flag", rmask_data[6], 1);
      @(negedge clk); r65_req = 1'b1; #1;
      chk("R1 edge beats upper level", irq_grant, 5'b01000);
      do_ack; #1;
      chk("R7 ack clears edge flag", rmask_data[6], 0);
      chk("R9 maskable ack drops enable", rmask_data[3], 0);
      chk("R3 disabled blocks level", irq_valid, 0);
      do_ei; #1;
      chk("R1 next source after re-enable", irq_grant, 5'b00100);
      @(negedge clk); r65_req = 1'b0;

      // R7 clear by set-mask bit 4
      pulse_edge; #1 chk("R7 flag set again", rmask_data[6], 1);
      wr_mask(8'h18); #1;
      chk("R7 bit4 clears flag", rmask_data[6], 0);
      chk("R7 bit4 clear leaves no grant", irq_valid, 0);

      // R7 capture while masked
      wr_mask(8'h0C);
      pulse_edge; #1;
      chk("R7 masked edge still flagged", rmask_data[6], 1);
      chk("R3 masked edge not granted", irq_valid, 0);
      wr_mask(8'h08); #1;
      chk("R5 unmask releases held edge", irq_grant, 5'b01000);
      wr_mask(8'h18);

      // R2 trap
      wr_mask(8'h0F);
      @(negedge clk); trap_req = 1'b1; #1;
      chk("R2 trap waits for clock edge", irq_valid, 0);
      @(negedge clk); #1;
      chk("R2 trap granted under masks", irq_grant, 5'b10000);
      chk("R4 trap vec", irq_vec, 16'h0024);
      do_ack; #1;
      chk("R2 held trap not re-granted", irq_valid, 0);
      chk("R9 trap ack keeps enable", rmask_data[3], 1);
      @(negedge clk); trap_req = 1'b0;
      @(negedge clk); trap_req = 1'b1;
      @(negedge clk); #1;
      chk("R2 new trap edge granted", irq_valid, 1);
      trap_req = 1'b0; #1;
      chk("R2 trap dropped before accept", irq_valid, 0);
      do_di;
      @(negedge clk); trap_req = 1'b1;
      @(negedge clk); #1;
      chk("R2 trap ignores disable", irq_grant, 5'b10000);
      do_ack;
      @(negedge clk); trap_req = 1'b0;

      // R5 / R6 set-mask gating
      wr_mask(8'hC8); #1;
      chk("R6 serial out set", ser_out, 1);
      chk("R5 masks loaded", rmask_data[2:0], 3'b000);
      wr_mask(8'h87); #1;
      chk("R6 serial held without bit6", ser_out, 1);
      chk("R5 masks held without bit3", rmask_data[2:0], 3'b000);
      wr_mask(8'h4F); #1;
      chk("R6 serial cleared", ser_out, 0);
      chk("R5 masks reloaded", rmask_data[2:0], 3'b111);

      // R8 read layout
      @(negedge clk); ser_in = 1'b1; r55_req = 1'b1; #1;
      chk("R8 read byte", rmask_data, 8'h97);
      @(negedge clk); ser_in = 1'b0; r55_req = 1'b0;

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule